// File: doc/BRIEF.md
# Vector Unit Access Trap Resolver

This block decides, for every cycle, whether an instruction or register access to the scalable vector unit may proceed at the current privilege level. It looks at the current level (0 to 3), the secure-state flag, whether the topmost level runs in 64-bit mode, and three control words: the level-1 access-control word, the level-2 trap-control word and the level-3 trap-control word. It returns a 2-bit level that must take the trap, where 0 means the access is allowed.

The verdict comes from a fixed chain of four tests: the vector enable field, then the floating-point enable field, then the level-2 trap bits, then the level-3 bits. The first test that traps sets the answer. The decision logic is purely combinational. A parameter places an optional register stage on the output, which gives a one-cycle latency. Field positions and control-word width are parameters and are checked when the design is elaborated.

Top module: `vec_trap_resolver`

## Requirements
- R1: When no test in the chain traps, trap_lvl is 0.
- R2: A vector enable field (os_ctl bits [17:16]) of 0 or 2 traps accesses made at level 0 or 1, with target 1. At level 2 or 3 it does not trap.
- R3: A vector enable field of 1 traps only accesses made at level 0. The target is always 1, even in secure state with a 32-bit top level.
- R4: A vector enable field of 3 never traps.
- R5: The floating-point enable field (os_ctl bits [21:20]) uses the same encoding as R2 to R4. It is tested only when the vector enable field did not trap.
- R6: A trap from either enable field under encoding 0 or 2 has target 3 instead of 1 when secure is 1 and top_aa64 is 0.
- R7: When neither enable field traps, a set bit 8 or bit 10 of hyp_ctl gives target 2. This applies only when the current level is 2 or lower and secure is 0.
- R8: When no earlier test traps, the target is 3 if bit 8 of mon_ctl (enable, active high) is clear or bit 10 of mon_ctl (trap) is set. This applies at every level.
- R9: The tests are applied strictly in the order vector field, floating-point field, level 2, level 3. The first one that traps decides the result.
- R10: Control-word bits other than os_ctl [21:20], os_ctl [17:16], hyp_ctl [10], hyp_ctl [8], mon_ctl [10] and mon_ctl [8] have no effect on trap_lvl.
- R11: With the output stage present, trap_lvl is 0 while rst_n is low. Otherwise it shows the verdict for the inputs of the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Asynchronous active-low reset of the output stage |
| cur_lvl | input | 2 | Current privilege level, 0 to 3 |
| secure | input | 1 | Core is in secure state |
| top_aa64 | input | 1 | Topmost level runs in 64-bit mode |
| os_ctl | input | CTRL_W | Level-1 access-control word |
| hyp_ctl | input | CTRL_W | Level-2 trap-control word |
| mon_ctl | input | CTRL_W | Level-3 trap-control word |
| trap_lvl | output | 2 | Level that takes the trap, 0 when the access is allowed |

## Verification
On every cycle the assertions check these relations against delayed copies of the inputs:
- both enable fields permissive means no level-1 target;
- an access at level 3 only ever resolves to 0 or 3;
- a clear level-3 enable bit always traps;
- the secure 32-bit redirect of an encoding-0 or encoding-2 vector trap;
- a fully permissive setting gives 0.

The bench's scenarios are needed for the rest. They show that the floating-point field yields to the vector field and the lower tests to the higher ones, the exact level-0-only reach of encoding 1, and that noise in unused bits has no effect. They also sweep every combination against a model built from the requirements.

// File: rtl/vtr_pkg.sv
package vtr_pkg;

   typedef logic [1:0] lvl_t;

   localparam lvl_t LVL_USR = 2'd0;
   localparam lvl_t LVL_OS  = 2'd1;
   localparam lvl_t LVL_HYP = 2'd2;
   localparam lvl_t LVL_MON = 2'd3;

   // encodings of a 2-bit enable field
   localparam logic [1:0] EN_OPEN     = 2'd3;
   localparam logic [1:0] EN_USR_ONLY = 2'd1;

   // one stage of the decision chain
   typedef struct packed {
      logic hit;
      lvl_t tgt;
   } verdict_t;

   localparam int NSTAGE = 4;

endpackage

// File: rtl/vtr_en_field_chk.sv
module vtr_en_field_chk
   import vtr_pkg::*;
(
   input  logic [1:0] field,
   input  lvl_t       cur_lvl,
   input  logic       redirect,
   output verdict_t   v
);

   always_comb begin
      v = '0;
      case (field)
         EN_OPEN: ;
         EN_USR_ONLY: begin
            if (cur_lvl == LVL_USR) begin
               v.hit = 1'b1;
               v.tgt = LVL_OS;
            end
         end
         default: begin
            if (cur_lvl <= LVL_OS) begin
               v.hit = 1'b1;
               v.tgt = redirect ? LVL_MON : LVL_OS;
            end
         end
      endcase
   end

endmodule

// File: rtl/vtr_hyp_chk.sv
module vtr_hyp_chk
   import vtr_pkg::*;
(
   input  logic     vec_trap,
   input  logic     fp_trap,
   input  lvl_t     cur_lvl,
   input  logic     secure,
   output verdict_t v
);

   logic below_top;
   logic secure_low;

   assign below_top  = (cur_lvl <= LVL_HYP);
   assign secure_low = secure && (cur_lvl != LVL_MON);

   always_comb begin
      v     = '0;
      v.hit = (vec_trap || fp_trap) && below_top && !secure_low;
      v.tgt = LVL_HYP;
   end

endmodule

// File: rtl/vtr_mon_chk.sv
module vtr_mon_chk
   import vtr_pkg::*;
(
   input  logic     vec_en,
   input  logic     fp_trap,
   output verdict_t v
);

   always_comb begin
      v     = '0;
      v.hit = !vec_en || fp_trap;
      v.tgt = LVL_MON;
   end

endmodule

// File: rtl/vtr_prio_pick.sv
module vtr_prio_pick
   import vtr_pkg::*;
#(
   parameter int N = NSTAGE
)(
   input  verdict_t vin [N],
   output lvl_t     lvl
);

   // lowest index wins: scan from the back so earlier stages overwrite
   always_comb begin
      lvl = LVL_USR;
      for (int i = N - 1; i >= 0; i--) begin
         if (vin[i].hit) lvl = vin[i].tgt;
      end
   end

endmodule

// File: rtl/vec_trap_resolver.sv
module vec_trap_resolver
   import vtr_pkg::*;
#(
   parameter int CTRL_W      = 64,
   parameter int VEC_EN_LSB  = 16,
   parameter int FP_EN_LSB   = 20,
   parameter int VEC_TRP_BIT = 8,
   parameter int FP_TRP_BIT  = 10,
   parameter bit REG_OUT     = 1'b1
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        cur_lvl,
   input  logic              secure,
   input  logic              top_aa64,
   input  logic [CTRL_W-1:0] os_ctl,
   input  logic [CTRL_W-1:0] hyp_ctl,
   input  logic [CTRL_W-1:0] mon_ctl,
   output logic [1:0]        trap_lvl
);

   localparam int HI_FIELD = (VEC_EN_LSB > FP_EN_LSB) ? VEC_EN_LSB + 1 : FP_EN_LSB + 1;
   localparam int HI_TRP   = (VEC_TRP_BIT > FP_TRP_BIT) ? VEC_TRP_BIT : FP_TRP_BIT;
   localparam int NFIELD   = 2;

   if (HI_FIELD >= CTRL_W || HI_TRP >= CTRL_W) begin : g_bad_width
      $error("control word too narrow for the chosen bit positions");
   end
   if (VEC_EN_LSB == FP_EN_LSB || VEC_EN_LSB == FP_EN_LSB + 1 ||
       FP_EN_LSB == VEC_EN_LSB + 1) begin : g_bad_fields
      $error("enable fields overlap");
   end
   if (VEC_TRP_BIT == FP_TRP_BIT) begin : g_bad_trp
      $error("trap bits must differ");
   end

   verdict_t stage [NSTAGE];
   logic     redirect;
   lvl_t     lvl_comb;

   assign redirect = secure && !top_aa64;

   for (genvar i = 0; i < NFIELD; i++) begin : g_field
      localparam int LSB = (i == 0) ? VEC_EN_LSB : FP_EN_LSB;
      vtr_en_field_chk u_fld (
         .field    (os_ctl[LSB +: 2]),
         .cur_lvl  (cur_lvl),
         .redirect (redirect),
         .v        (stage[i])
      );
   end

   vtr_hyp_chk u_hyp (
      .vec_trap (hyp_ctl[VEC_TRP_BIT]),
      .fp_trap  (hyp_ctl[FP_TRP_BIT]),
      .cur_lvl  (cur_lvl),
      .secure   (secure),
      .v        (stage[NFIELD])
   );

   vtr_mon_chk u_mon (
      .vec_en  (mon_ctl[VEC_TRP_BIT]),
      .fp_trap (mon_ctl[FP_TRP_BIT]),
      .v       (stage[NFIELD+1])
   );

   vtr_prio_pick #(.N(NSTAGE)) u_pick (
      .vin (stage),
      .lvl (lvl_comb)
   );

   if (REG_OUT) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) trap_lvl <= LVL_USR;
         else        trap_lvl <= lvl_comb;
      end
   end else begin : g_comb
      assign trap_lvl = lvl_comb;
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
   end

   logic unused_bits;
   assign unused_bits = ^{os_ctl, hyp_ctl, mon_ctl};

endmodule

// File: rtl/vtr_chk.sv
module vtr_chk #(
   parameter int CTRL_W      = 64,
   parameter int VEC_EN_LSB  = 16,
   parameter int FP_EN_LSB   = 20,
   parameter int VEC_TRP_BIT = 8,
   parameter int FP_TRP_BIT  = 10,
   parameter bit REG_OUT     = 1'b1
)(
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        cur_lvl,
   input logic              secure,
   input logic              top_aa64,
   input logic [CTRL_W-1:0] os_ctl,
   input logic [CTRL_W-1:0] hyp_ctl,
   input logic [CTRL_W-1:0] mon_ctl,
   input logic [1:0]        trap_lvl
);

   logic [1:0]        o_lvl;
   logic              o_sec, o_aa64;
   logic [CTRL_W-1:0] o_os, o_hyp, o_mon;
   logic              seen;

   if (REG_OUT) begin : g_dly
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            o_lvl <= '0; o_sec <= 1'b0; o_aa64 <= 1'b0;
            o_os <= '0; o_hyp <= '0; o_mon <= '0;
         end else begin
            o_lvl <= cur_lvl; o_sec <= secure; o_aa64 <= top_aa64;
            o_os <= os_ctl; o_hyp <= hyp_ctl; o_mon <= mon_ctl;
         end
      end
   end else begin : g_now
      assign o_lvl = cur_lvl; assign o_sec = secure; assign o_aa64 = top_aa64;
      assign o_os = os_ctl; assign o_hyp = hyp_ctl; assign o_mon = mon_ctl;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen <= 1'b0;
      else        seen <= 1'b1;
   end

   logic [1:0] vf, ff;
   assign vf = o_os[VEC_EN_LSB +: 2];
   assign ff = o_os[FP_EN_LSB +: 2];

   // R4 with R5: both enable fields open means no level-1 target
   a_r4_fields_open_no_os: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && vf == 2'd3 && ff == 2'd3) |-> (trap_lvl != 2'd1));

   // R7: an access at level 3 never resolves to level 1 or 2
   a_r7_top_level_only_mon: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && o_lvl == 2'd3) |-> (trap_lvl == 2'd0 || trap_lvl == 2'd3));

   // R8: clear level-3 enable always traps somewhere
   a_r8_mon_enable_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && !o_mon[VEC_TRP_BIT]) |-> (trap_lvl != 2'd0));

   // R6: secure 32-bit redirect of a vector field trap
   a_r6_secure_redirect: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && o_sec && !o_aa64 && o_lvl <= 2'd1 && !vf[0]) |-> (trap_lvl == 2'd3));

   // R1: fully permissive setting allows access
   a_r1_all_open: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && vf == 2'd3 && ff == 2'd3 && !o_hyp[VEC_TRP_BIT] && !o_hyp[FP_TRP_BIT]
       && o_mon[VEC_TRP_BIT] && !o_mon[FP_TRP_BIT]) |-> (trap_lvl == 2'd0));

   // R11: output cleared while reset is held
   always @(negedge clk) begin
      if (REG_OUT && !rst_n) begin
         a_r11_reset_clear: assert (trap_lvl == 2'd0);
      end
   end

   logic unused_chk;
   assign unused_chk = ^{o_os, o_hyp, o_mon};

endmodule

bind vec_trap_resolver vtr_chk #(
   .CTRL_W      (CTRL_W),
   .VEC_EN_LSB  (VEC_EN_LSB),
   .FP_EN_LSB   (FP_EN_LSB),
   .VEC_TRP_BIT (VEC_TRP_BIT),
   .FP_TRP_BIT  (FP_TRP_BIT),
   .REG_OUT     (REG_OUT)
) u_chk (.*);

// File: tb/vec_trap_resolver_tb.sv
`timescale 1ns/1ps
module vec_trap_resolver_tb;

   localparam int W = 64;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [1:0]   cur_lvl = 2'd0;
   logic         secure = 1'b0;
   logic         top_aa64 = 1'b1;
   logic [W-1:0] os_ctl = '0;
   logic [W-1:0] hyp_ctl = '0;
   logic [W-1:0] mon_ctl = '0;
   logic [1:0]   trap_lvl;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   vec_trap_resolver u_dut (
      .clk(clk), .rst_n(rst_n), .cur_lvl(cur_lvl), .secure(secure),
      .top_aa64(top_aa64), .os_ctl(os_ctl), .hyp_ctl(hyp_ctl),
      .mon_ctl(mon_ctl), .trap_lvl(trap_lvl)
   );

   localparam logic [W-1:0] KEEP = (64'h3 << 16) | (64'h3 << 20);
   localparam logic [W-1:0] TKEEP = (64'h1 << 8) | (64'h1 << 10);

   function automatic logic [1:0] ref_lvl(input logic [1:0] l, input logic s,
         input logic a, input logic [1:0] vf, input logic [1:0] ff,
         input logic h8, input logic h10, input logic m8, input logic m10);
      logic [1:0] f [2];
      f[0] = vf; f[1] = ff;
      for (int k = 0; k < 2; k++) begin
         if (f[k] == 2'd1) begin
            if (l == 2'd0) return 2'd1;
         end else if (f[k] != 2'd3) begin
            if (l <= 2'd1) return (s && !a) ? 2'd3 : 2'd1;
         end
      end
      if ((h8 || h10) && l <= 2'd2 && !s) return 2'd2;
      if (!m8 || m10) return 2'd3;
      return 2'd0;
   endfunction

   task automatic chk(input string req, input logic [1:0] got, input logic [1:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s got %0d expected %0d", req, got, exp);
      end
   endtask

   // drive at a falling edge, result visible at the next falling edge
   task automatic run(input logic [1:0] l, input logic s, input logic a,
         input logic [1:0] vf, input logic [1:0] ff, input logic h8, input logic h10,
         input logic m8, input logic m10, input logic [W-1:0] noise,
         output logic [1:0] got);
      @(negedge clk);
      cur_lvl = l; secure = s; top_aa64 = a;
      os_ctl  = (noise & ~KEEP) | (W'(vf) << 16) | (W'(ff) << 20);
      hyp_ctl = (~noise & ~TKEEP) | (W'(h8) << 8) | (W'(h10) << 10);
      mon_ctl = (noise & ~TKEEP) | (W'(m8) << 8) | (W'(m10) << 10);
      @(negedge clk);
      got = trap_lvl;
   endtask

   task automatic t_reset();
      logic [1:0] g;
      cur_lvl = 2'd0; os_ctl = '0;
      repeat (3) @(negedge clk);
      g = trap_lvl;
      chk("R11 reset", g, 2'd0);
      rst_n = 1'b1;
   endtask

   task automatic t_permit();
      logic [1:0] g;
      for (int l = 0; l < 4; l++) begin
         run(2'(l), 1'b0, 1'b1, 2'd3, 2'd3, 1'b0, 1'b0, 1'b1, 1'b0, '0, g);
         chk("R1 permit", g, 2'd0);
      end
   endtask

   task automatic t_vec_field();
      logic [1:0] g;
      run(2'd0, 0, 1, 2'd0, 2'd3, 0, 0, 1, 0, '0, g); chk("R2 enc0 l0", g, 2'd1);
      run(2'd1, 0, 1, 2'd2, 2'd3, 0, 0, 1, 0, '0, g); chk("R2 enc2 l1", g, 2'd1);
      run(2'd2, 0, 1, 2'd0, 2'd3, 0, 0, 1, 0, '0, g); chk("R2 enc0 l2", g, 2'd0);
      run(2'd0, 0, 1, 2'd1, 2'd3, 0, 0, 1, 0, '0, g); chk("R3 enc1 l0", g, 2'd1);
      run(2'd1, 0, 1, 2'd1, 2'd3, 0, 0, 1, 0, '0, g); chk("R3 enc1 l1", g, 2'd0);
      run(2'd0, 1, 0, 2'd1, 2'd3, 0, 0, 1, 0, '0, g); chk("R3 enc1 no redirect", g, 2'd1);
      run(2'd0, 0, 1, 2'd3, 2'd3, 0, 0, 1, 0, '0, g); chk("R4 enc3 l0", g, 2'd0);
      run(2'd1, 1, 0, 2'd0, 2'd3, 0, 0, 1, 0, '0, g); chk("R6 redirect", g, 2'd3);
      run(2'd1, 1, 1, 2'd2, 2'd3, 0, 0, 1, 0, '0, g); chk("R6 aa64 no redirect", g, 2'd1);
   endtask

   task automatic t_fp_field();
      logic [1:0] g;
      run(2'd1, 0, 1, 2'd3, 2'd0, 0, 0, 1, 0, '0, g); chk("R5 fp enc0", g, 2'd1);
      run(2'd0, 1, 0, 2'd1, 2'd0, 0, 0, 1, 0, '0, g); chk("R5 vec wins over fp", g, 2'd1);
      run(2'd0, 1, 0, 2'd3, 2'd2, 0, 0, 1, 0, '0, g); chk("R5 fp redirect", g, 2'd3);
      run(2'd1, 0, 1, 2'd3, 2'd1, 0, 0, 1, 0, '0, g); chk("R5 fp enc1 l1", g, 2'd0);
   endtask

   task automatic t_hyp();
      logic [1:0] g;
      run(2'd2, 0, 1, 2'd3, 2'd3, 1, 0, 1, 0, '0, g); chk("R7 vec bit", g, 2'd2);
      run(2'd0, 0, 1, 2'd3, 2'd3, 0, 1, 1, 0, '0, g); chk("R7 fp bit", g, 2'd2);
      run(2'd1, 1, 1, 2'd3, 2'd3, 1, 1, 1, 0, '0, g); chk("R7 secure skip", g, 2'd0);
      run(2'd3, 0, 1, 2'd3, 2'd3, 1, 1, 1, 0, '0, g); chk("R7 level3 skip", g, 2'd0);
      run(2'd1, 0, 1, 2'd0, 2'd3, 1, 0, 1, 0, '0, g); chk("R9 field before hyp", g, 2'd1);
   endtask

   task automatic t_mon();
      logic [1:0] g;
      run(2'd3, 0, 1, 2'd3, 2'd3, 0, 0, 0, 0, '0, g); chk("R8 enable clear", g, 2'd3);
      run(2'd0, 1, 1, 2'd3, 2'd3, 0, 0, 1, 1, '0, g); chk("R8 trap set", g, 2'd3);
      run(2'd2, 0, 1, 2'd3, 2'd3, 1, 0, 0, 1, '0, g); chk("R9 hyp before mon", g, 2'd2);
   endtask

   task automatic t_ignored();
      logic [1:0] g;
      logic [W-1:0] nz [3];
      nz[0] = 64'hFFFF_FFFF_FFFF_FFFF; nz[1] = 64'hA5C3_0F96_5A3C_F069; nz[2] = 64'h0123_4567_89AB_CDEF;
      for (int i = 0; i < 3; i++) begin
         run(2'd2, 0, 1, 2'd3, 2'd3, 0, 0, 1, 0, nz[i], g); chk("R10 noise open", g, 2'd0);
         run(2'd1, 0, 1, 2'd1, 2'd3, 0, 0, 1, 0, nz[i], g); chk("R10 noise enc1", g, 2'd0);
      end
   endtask

   task automatic t_latency();
      logic [1:0] g;
      run(2'd2, 0, 1, 2'd3, 2'd3, 0, 0, 1, 0, '0, g);
      @(negedge clk);
      mon_ctl = '0;
      #1 g = trap_lvl;
      chk("R11 holds before edge", g, 2'd0);
      @(negedge clk);
      g = trap_lvl;
      chk("R11 updates after edge", g, 2'd3);
   endtask

   task automatic t_sweep();
      logic [1:0] g;
      logic [W-1:0] nz;
      for (int l = 0; l < 4; l++)
      for (int vf = 0; vf < 4; vf++)
      for (int ff = 0; ff < 4; ff++)
      for (int s = 0; s < 2; s++)
      for (int a = 0; a < 2; a++)
      for (int h = 0; h < 4; h++)
      for (int m = 0; m < 4; m++) begin
         nz = {16'(l * 37 + m), 16'(vf * 91 + h), 16'(ff * 13 + s), 16'(a * 7 + 5)};
         run(2'(l), s[0], a[0], 2'(vf), 2'(ff), h[0], h[1], m[0], m[1], nz, g);
         chk("R9 sweep", g, ref_lvl(2'(l), s[0], a[0], 2'(vf), 2'(ff), h[0], h[1], m[0], m[1]));
      end
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog got 0 expected 1");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_permit();
      t_vec_field();
      t_fp_field();
      t_hyp();
      t_mon();
      t_ignored();
      t_latency();
      t_sweep();
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule